// File: doc/BRIEF.md
# Banked Effective Address Generator

This block turns an addressing-mode code, up to three operand bytes and the processor's address-forming registers into a 24-bit effective address. The address-forming registers are the direct-page base, the data bank and the two index registers. It also reports how many extra bus cycles the mode costs. There are two separate penalties. Direct-page forms cost one more cycle when the low byte of the direct-page base is nonzero. Indexed reads cost one more cycle when the index moves the address into a different 256-byte page.

The indirect forms need a 16-bit pointer from memory. For these, the block runs a two-step fetch with a request/acknowledge pair: it asks for the low byte, then the high byte, and it forms the final address only after both bytes have arrived. Every other mode finishes in one clock. The memory bus itself is outside the block; the surrounding pipeline answers the pointer requests.

Top module: `bank_ea_gen`

## Requirements
- R1: Mode codes are 0 direct, 1 direct+X, 2 direct+Y, 3 direct indirect, 4 direct indirect then +Y, 5 direct+X then indirect, 6 absolute, 7 absolute+X, 8 absolute+Y, 9 long, 10 long+X. For a non-indirect mode, `done` is high for exactly the one cycle after the clock edge that accepts `start`, and `eff_addr`/`extra_cyc` are valid in that cycle.
- R2: A direct-page address is (dp_base + opnd_lo + index), wrapped to 16 bits, with the bank byte 0. Only mode 1 adds X and only mode 2 adds Y; mode 0 adds no index.
- R3: When `idx_short` is 1, only bits 7:0 of the index register are added, in every indexed mode.
- R4: Every direct-page mode (0 to 5) adds one extra cycle when dp_base[7:0] is nonzero.
- R5: An absolute address is {data_bank, opnd_hi, opnd_lo}. The indexed forms add the index to this full 24-bit value, so a carry goes into the bank byte.
- R6: Modes 7, 8 and 4 add one extra cycle when the indexed address lies in a different 256-byte page (bits 23:8) than the unindexed base.
- R7: A long address is {opnd_bank, opnd_hi, opnd_lo}. Mode 10 adds X with 24-bit wraparound. Long modes never add extra cycles.
- R8: The indirect modes raise `ptr_req` with `ptr_addr` set to the direct-page pointer address. That address includes X for mode 5. On `ptr_ack`, the request moves to that address + 1 (16-bit wrap, bank 0). `ptr_req` and `ptr_addr` hold while `ptr_ack` is low. `done` follows in the cycle after the second accepted byte.
- R9: An indirect result is {data_bank, ptr_hi, ptr_lo}. Mode 4 then adds Y as a 24-bit add; mode 5 adds no index after the fetch.
- R10: `start` is ignored while `busy` is high; the fetch in progress completes with its own operands.
- R11: After reset, `done`, `busy` and `ptr_req` are 0, and `eff_addr` and `extra_cyc` are 0.
- R12: Reserved codes 11 to 15 behave as plain absolute (mode 6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an address computation with the current inputs |
| mode | input | 4 | Addressing mode code |
| opnd_lo | input | 8 | First operand byte |
| opnd_hi | input | 8 | Second operand byte |
| opnd_bank | input | 8 | Third operand byte (long modes) |
| dp_base | input | 16 | Direct-page base register |
| data_bank | input | 8 | Data bank register |
| idx_x | input | 16 | X index register |
| idx_y | input | 16 | Y index register |
| idx_short | input | 1 | 1 selects 8-bit index width |
| ptr_req | output | 1 | Pointer byte request |
| ptr_addr | output | 24 | Address of the requested pointer byte |
| ptr_ack | input | 1 | Pointer byte delivered this cycle |
| ptr_byte | input | 8 | Pointer byte data |
| busy | output | 1 | Pointer fetch in progress |
| done | output | 1 | Result valid pulse |
| eff_addr | output | 24 | Effective address |
| extra_cyc | output | 2 | Extra bus cycles for this access (0 to 2) |

## Verification
Non-indirect results are due one cycle after the edge that accepts `start`. Indirect results are due one cycle after the edge that accepts the second pointer byte. The first pointer request is visible one cycle after `start`, and the request moves to the next address one cycle after each accepted low byte. The bench changes inputs on the falling edge and samples at the next falling edge after the edge where each result is due. It checks `done` in that cycle and checks that it has dropped in the following one. It also holds `ptr_ack` low for several cycles to confirm that the request holds while stalled.

// File: rtl/bank_ea_pkg.sv
package bank_ea_pkg;
  localparam int WORD_W  = 16;
  localparam int BYTE_W  = 8;
  localparam int BANK_W  = 8;
  localparam int ADDR_W  = BANK_W + WORD_W;
  localparam int PAGE_W  = 8;
  localparam int MODE_W  = 4;
  localparam int EXTRA_W = 2;

  typedef enum logic [MODE_W-1:0] {
    AM_DIR      = 4'd0,
    AM_DIR_X    = 4'd1,
    AM_DIR_Y    = 4'd2,
    AM_IND      = 4'd3,
    AM_IND_Y    = 4'd4,
    AM_IND_PREX = 4'd5,
    AM_ABS      = 4'd6,
    AM_ABS_X    = 4'd7,
    AM_ABS_Y    = 4'd8,
    AM_LONG     = 4'd9,
    AM_LONG_X   = 4'd10
  } amode_e;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_LO   = 2'd1,
    FS_HI   = 2'd2
  } fetch_st_e;
endpackage

// File: rtl/ea_dp_unit.sv
// Direct-page address former: base + offset + optional (possibly narrowed) index.
module ea_dp_unit #(
  parameter int WORD_W  = 16,
  parameter int OFS_W   = 8,
  parameter int SHORT_W = 8
) (
  input  logic [WORD_W-1:0] base,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [WORD_W-1:0] idx,
  input  logic              idx_short,
  input  logic              add_idx,
  output logic [WORD_W-1:0] addr,
  output logic              misalign
);
  logic [WORD_W-1:0] idx_eff;

  always_comb begin
    if (!add_idx)       idx_eff = '0;
    else if (idx_short) idx_eff = WORD_W'(idx[SHORT_W-1:0]);
    else                idx_eff = idx;
    addr     = base + WORD_W'(ofs) + idx_eff;
    misalign = |base[OFS_W-1:0];
  end
endmodule

// File: rtl/ea_bank_unit.sv
// Full-width indexed add with page-crossing detection.
module ea_bank_unit #(
  parameter int ADDR_W  = 24,
  parameter int WORD_W  = 16,
  parameter int PAGE_W  = 8,
  parameter int SHORT_W = 8
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [WORD_W-1:0] idx,
  input  logic              idx_short,
  input  logic              add_idx,
  output logic [ADDR_W-1:0] addr,
  output logic              page_cross
);
  logic [WORD_W-1:0] idx_eff;

  always_comb begin
    if (!add_idx)       idx_eff = '0;
    else if (idx_short) idx_eff = WORD_W'(idx[SHORT_W-1:0]);
    else                idx_eff = idx;
    addr       = base + ADDR_W'(idx_eff);
    page_cross = addr[ADDR_W-1:PAGE_W] != base[ADDR_W-1:PAGE_W];
  end
endmodule

// File: rtl/ea_ptr_seq.sv
// Two-step little-endian pointer fetch with request/acknowledge.
module ea_ptr_seq
  import bank_ea_pkg::*;
#(
  parameter int PW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          launch,
  input  logic [PW-1:0] base,
  input  logic          ack,
  input  logic [BW-1:0] byte_in,
  output logic          req,
  output logic [PW-1:0] addr,
  output logic          valid,
  output logic [PW-1:0] ptr,
  output logic          busy
);
  fetch_st_e     st_q, st_d;
  logic [PW-1:0] base_q;
  logic [BW-1:0] lo_q;
  logic          base_en, lo_en;

  always_comb begin
    st_d = st_q;
    case (st_q)
      FS_IDLE: if (launch) st_d = FS_LO;
      FS_LO:   if (ack)    st_d = FS_HI;
      FS_HI:   if (ack)    st_d = FS_IDLE;
      default:             st_d = FS_IDLE;
    endcase
    base_en = (st_q == FS_IDLE) && launch;
    lo_en   = (st_q == FS_LO) && ack;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= FS_IDLE;
      base_q <= '0;
      lo_q   <= '0;
    end else begin
      st_q <= st_d;
      if (base_en) base_q <= base;
      if (lo_en)   lo_q   <= byte_in;
    end
  end

  always_comb begin
    req   = (st_q == FS_LO) || (st_q == FS_HI);
    busy  = req;
    addr  = (st_q == FS_HI) ? base_q + PW'(1) : base_q;
    valid = (st_q == FS_HI) && ack;
    ptr   = {byte_in, lo_q};
  end

  // R8: an unanswered request holds its address
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    req && !ack |=> req && $stable(addr));
  // R8: accepting the low byte moves the request to the following address
  p_lo_to_hi_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == FS_LO) && ack |=> req && (addr == $past(addr) + PW'(1)));
endmodule

// File: rtl/bank_ea_gen.sv
module bank_ea_gen
  import bank_ea_pkg::*;
#(
  parameter int WORD_W_P = WORD_W,
  parameter int BANK_W_P = BANK_W,
  parameter int BYTE_W_P = BYTE_W,
  parameter int PAGE_W_P = PAGE_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [MODE_W-1:0]           mode,
  input  logic [BYTE_W_P-1:0]         opnd_lo,
  input  logic [BYTE_W_P-1:0]         opnd_hi,
  input  logic [BANK_W_P-1:0]         opnd_bank,
  input  logic [WORD_W_P-1:0]         dp_base,
  input  logic [BANK_W_P-1:0]         data_bank,
  input  logic [WORD_W_P-1:0]         idx_x,
  input  logic [WORD_W_P-1:0]         idx_y,
  input  logic                        idx_short,
  output logic                        ptr_req,
  output logic [BANK_W_P+WORD_W_P-1:0] ptr_addr,
  input  logic                        ptr_ack,
  input  logic [BYTE_W_P-1:0]         ptr_byte,
  output logic                        busy,
  output logic                        done,
  output logic [BANK_W_P+WORD_W_P-1:0] eff_addr,
  output logic [EXTRA_W-1:0]          extra_cyc
);
  localparam int AW = BANK_W_P + WORD_W_P;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // mode decode
  amode_e am;
  logic   is_dp, is_ind, dp_add_idx, dp_use_y, bk_add_idx, bk_use_y, bk_long, bk_pen;
  always_comb begin
    am         = amode_e'(mode);
    is_dp      = (am == AM_DIR) || (am == AM_DIR_X) || (am == AM_DIR_Y);
    is_ind     = (am == AM_IND) || (am == AM_IND_Y) || (am == AM_IND_PREX);
    dp_add_idx = (am == AM_DIR_X) || (am == AM_DIR_Y) || (am == AM_IND_PREX);
    dp_use_y   = (am == AM_DIR_Y);
    bk_add_idx = (am == AM_ABS_X) || (am == AM_ABS_Y) || (am == AM_LONG_X);
    bk_use_y   = (am == AM_ABS_Y);
    bk_long    = (am == AM_LONG) || (am == AM_LONG_X);
    bk_pen     = (am == AM_ABS_X) || (am == AM_ABS_Y);
  end

  // direct-page former (also forms the pointer address)
  logic [WORD_W_P-1:0] dp_addr;
  logic                dp_mis;
  ea_dp_unit #(.WORD_W(WORD_W_P), .OFS_W(BYTE_W_P), .SHORT_W(BYTE_W_P)) u_dp (
    .base(dp_base), .ofs(opnd_lo), .idx(dp_use_y ? idx_y : idx_x),
    .idx_short(idx_short), .add_idx(dp_add_idx), .addr(dp_addr), .misalign(dp_mis));

  // absolute / long former
  logic [AW-1:0] bk_base, bk_addr;
  logic          bk_cross;
  assign bk_base = bk_long ? {opnd_bank, opnd_hi, opnd_lo} : {data_bank, opnd_hi, opnd_lo};
  ea_bank_unit #(.ADDR_W(AW), .WORD_W(WORD_W_P), .PAGE_W(PAGE_W_P), .SHORT_W(BYTE_W_P)) u_bk (
    .base(bk_base), .idx(bk_use_y ? idx_y : idx_x), .idx_short(idx_short),
    .add_idx(bk_add_idx), .addr(bk_addr), .page_cross(bk_cross));

  // operands kept for the post-fetch stage
  logic                accept, hold_en;
  logic [BANK_W_P-1:0] db_q;
  logic [WORD_W_P-1:0] y_q;
  logic                yadd_q, short_q, mis_q;
  logic                seq_busy;
  assign accept  = start && !seq_busy;
  assign hold_en = accept && is_ind;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      db_q    <= '0;
      y_q     <= '0;
      yadd_q  <= 1'b0;
      short_q <= 1'b0;
      mis_q   <= 1'b0;
    end else if (hold_en) begin
      db_q    <= data_bank;
      y_q     <= idx_y;
      yadd_q  <= (am == AM_IND_Y);
      short_q <= idx_short;
      mis_q   <= dp_mis;
    end
  end

  // pointer fetch
  logic [WORD_W_P-1:0] seq_addr, ptr_word;
  logic                ptr_valid;
  ea_ptr_seq #(.PW(WORD_W_P), .BW(BYTE_W_P)) u_seq (
    .clk(clk), .rst_ni(rst_ni), .launch(hold_en), .base(dp_addr),
    .ack(ptr_ack), .byte_in(ptr_byte), .req(ptr_req), .addr(seq_addr),
    .valid(ptr_valid), .ptr(ptr_word), .busy(seq_busy));
  assign ptr_addr = {{BANK_W_P{1'b0}}, seq_addr};
  assign busy     = seq_busy;

  // post-fetch former
  logic [AW-1:0] ind_addr;
  logic          ind_cross;
  ea_bank_unit #(.ADDR_W(AW), .WORD_W(WORD_W_P), .PAGE_W(PAGE_W_P), .SHORT_W(BYTE_W_P)) u_ind (
    .base({db_q, ptr_word}), .idx(y_q), .idx_short(short_q), .add_idx(yadd_q),
    .addr(ind_addr), .page_cross(ind_cross));

  // result stage
  logic [AW-1:0]      ea_d;
  logic [EXTRA_W-1:0] ext_d;
  logic               done_d, res_en;
  always_comb begin
    done_d = (accept && !is_ind) || ptr_valid;
    res_en = done_d;
    if (ptr_valid) begin
      ea_d  = ind_addr;
      ext_d = EXTRA_W'(mis_q) + EXTRA_W'(yadd_q && ind_cross);
    end else if (is_dp) begin
      ea_d  = {{BANK_W_P{1'b0}}, dp_addr};
      ext_d = EXTRA_W'(dp_mis);
    end else begin
      ea_d  = bk_addr;
      ext_d = EXTRA_W'(bk_pen && bk_cross);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      done      <= 1'b0;
      eff_addr  <= '0;
      extra_cyc <= '0;
    end else begin
      done <= done_d;
      if (res_en) begin
        eff_addr  <= ea_d;
        extra_cyc <= ext_d;
      end
    end
  end

  // R1: a non-indirect start yields done on the next cycle
  p_done_next_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    start && !busy && !is_ind |=> done);
  // R8: requests only while a fetch is in progress
  p_req_in_fetch_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    ptr_req |-> busy);
  // R10: during a fetch, done only follows an acknowledged byte
  p_fetch_done_ack_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    busy && !ptr_ack |=> !done);
  // R2: direct-page results stay in bank 0
  p_dp_bank0_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    accept && is_dp |=> eff_addr[AW-1:WORD_W_P] == '0);
  // R4: misaligned direct base costs one cycle on plain direct forms
  p_dp_penalty_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    accept && is_dp && (dp_base[BYTE_W_P-1:0] != '0) |=> extra_cyc == EXTRA_W'(1));
endmodule

// File: tb/bank_ea_gen_bench.sv
module bank_ea_gen_bench;
  typedef struct packed {
    logic [3:0]  md;
    logic        sh;
    logic [15:0] d;
    logic [7:0]  db;
    logic [7:0]  bk;
    logic [7:0]  hi;
    logic [7:0]  lo;
    logic [15:0] x;
    logic [15:0] y;
    logic [7:0]  plo;
    logic [7:0]  phi;
    logic [23:0] pa;
    logic [23:0] ea;
    logic [1:0]  ext;
  } vec_t;

  // mode,short,d,db,bank,hi,lo,x,y,plo,phi,ptr_addr,ea,extra
  localparam vec_t VECS [0:20] = '{
    '{4'd0, 1'b0, 16'h1200, 8'h00, 8'h00, 8'h00, 8'h34, 16'h0000, 16'h0000, 8'h00, 8'h00, 24'h0, 24'h001234, 2'd0}, // R2
    '{4'd0, 1'b0, 16'h12F0, 8'h00, 8'h00, 8'h00, 8'h20, 16'h0000, 16'h0000, 8'h00, 8'h00, 24'h0, 24'h001310, 2'd1}, // R4
    '{4'd0, 1'b0, 16'hFFF0, 8'h55, 8'h00, 8'h00, 8'h20, 16'h0000, 16'h0000, 8'h00, 8'h00, 24'h0, 24'h000010, 2'd1}, // R2 wrap
    '{4'd1, 1'b1, 16'h0100, 8'h00, 8'h00, 8'h00, 8'h10, 16'h3456, 16'h0000, 8'h00, 8'h00, 24'h0, 24'h000166, 2'd0}, // R3
    '{4'd1, 1'b0, 16'h0100, 8'h00, 8'h00, 8'h00, 8'h10, 16'h3456, 16'h0000, 8'h00, 8'h00, 24'h0, 24'h003566, 2'd0}, // R2
    '{4'd2, 1'b0, 16'h2000, 8'h00, 8'h00, 8'h00, 8'h05, 16'h0700, 16'h0010, 8'h00, 8'h00, 24'h0, 24'h002015, 2'd0}, // R2 Y
    '{4'd6, 1'b0, 16'h0000, 8'h7E, 8'h00, 8'h12, 8'h34, 16'h0000, 16'h0000, 8'h00, 8'h00, 24'h0, 24'h7E1234, 2'd0}, // R5
    '{4'd7, 1'b0, 16'h0000, 8'h7E, 8'h00, 8'h12, 8'h34, 16'h0010, 16'h0000, 8'h00, 8'h00, 24'h0, 24'h7E1244, 2'd0}, // R5
    '{4'd7, 1'b0, 16'h0000, 8'h7E, 8'h00, 8'h12, 8'hF0, 16'h0020, 16'h0000, 8'h00, 8'h00, 24'h0, 24'h7E1310, 2'd1}, // R6
    '{4'd8, 1'b0, 16'h0000, 8'h7E, 8'h00, 8'hFF, 8'hF0, 16'h0000, 16'h0020, 8'h00, 8'h00, 24'h0, 24'h7F0010, 2'd1}, // R5 carry
    '{4'd8, 1'b1, 16'h0000, 8'h7E, 8'h00, 8'h12, 8'h00, 16'h0000, 16'hAB05, 8'h00, 8'h00, 24'h0, 24'h7E1205, 2'd0}, // R3
    '{4'd9, 1'b0, 16'h0000, 8'h7E, 8'h12, 8'h34, 8'h56, 16'h0000, 16'h0000, 8'h00, 8'h00, 24'h0, 24'h123456, 2'd0}, // R7
    '{4'd10,1'b0, 16'h0000, 8'h7E, 8'h12, 8'hFF, 8'hF0, 16'h0020, 16'h0000, 8'h00, 8'h00, 24'h0, 24'h130010, 2'd0}, // R7
    '{4'd10,1'b0, 16'h0000, 8'h00, 8'hFF, 8'hFF, 8'hFF, 16'h0001, 16'h0000, 8'h00, 8'h00, 24'h0, 24'h000000, 2'd0}, // R7 wrap
    '{4'd15,1'b0, 16'h0000, 8'h01, 8'h99, 8'h22, 8'h33, 16'h0005, 16'h0000, 8'h00, 8'h00, 24'h0, 24'h012233, 2'd0}, // R12
    '{4'd3, 1'b0, 16'h0300, 8'h11, 8'h00, 8'h00, 8'h40, 16'h0000, 16'h0000, 8'h78, 8'h56, 24'h000340, 24'h115678, 2'd0}, // R9
    '{4'd4, 1'b0, 16'h0301, 8'h11, 8'h00, 8'h00, 8'h40, 16'h0000, 16'h0010, 8'hF8, 8'h56, 24'h000341, 24'h115708, 2'd2}, // R6 R4
    '{4'd5, 1'b0, 16'h0300, 8'h22, 8'h00, 8'h00, 8'h40, 16'h0005, 16'hFFFF, 8'hBC, 8'h9A, 24'h000345, 24'h229ABC, 2'd0}, // R9
    '{4'd3, 1'b0, 16'hFF00, 8'h00, 8'h00, 8'h00, 8'hFF, 16'h0000, 16'h0000, 8'h34, 8'h12, 24'h00FFFF, 24'h001234, 2'd0}, // R8 wrap
    '{4'd4, 1'b0, 16'h0000, 8'h7E, 8'h00, 8'h00, 8'h10, 16'h0000, 16'h0001, 8'hFF, 8'hFF, 24'h000010, 24'h7F0000, 2'd1}, // R9 carry
    '{4'd5, 1'b1, 16'h0400, 8'h33, 8'h00, 8'h00, 8'h10, 16'hFF20, 16'h0000, 8'h00, 8'h80, 24'h000430, 24'h338000, 2'd0}  // R3
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [7:0]  opnd_lo = '0, opnd_hi = '0, opnd_bank = '0, data_bank = '0, ptr_byte = '0;
  logic [15:0] dp_base = '0, idx_x = '0, idx_y = '0;
  logic        idx_short = 1'b0, ptr_ack = 1'b0;
  logic        ptr_req, busy, done;
  logic [23:0] ptr_addr, eff_addr;
  logic [1:0]  extra_cyc;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  bank_ea_gen u_bank_ea_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .opnd_lo(opnd_lo),
    .opnd_hi(opnd_hi), .opnd_bank(opnd_bank), .dp_base(dp_base), .data_bank(data_bank),
    .idx_x(idx_x), .idx_y(idx_y), .idx_short(idx_short), .ptr_req(ptr_req),
    .ptr_addr(ptr_addr), .ptr_ack(ptr_ack), .ptr_byte(ptr_byte), .busy(busy),
    .done(done), .eff_addr(eff_addr), .extra_cyc(extra_cyc));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string addr_tag(input vec_t v);
    if (v.sh) return "R3";
    if (v.md <= 4'd2) return "R2";
    if (v.md <= 4'd5) return "R9";
    if (v.md <= 4'd8) return "R5";
    if (v.md <= 4'd10) return "R7";
    return "R12";
  endfunction

  function automatic string ext_tag(input vec_t v);
    if (v.md <= 4'd2) return "R4";
    if (v.md >= 4'd9 && v.md <= 4'd10) return "R7";
    return "R6";
  endfunction

  task automatic load(input vec_t v);
    mode = v.md; idx_short = v.sh; dp_base = v.d; data_bank = v.db;
    opnd_bank = v.bk; opnd_hi = v.hi; opnd_lo = v.lo; idx_x = v.x; idx_y = v.y;
  endtask

  task automatic run_vec(input vec_t v, input int stall);
    logic ind;
    ind = (v.md >= 4'd3) && (v.md <= 4'd5);
    @(negedge clk);
    load(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (ind) begin
      for (int b = 0; b < 2; b++) begin
        chk("R8 req", 32'(ptr_req), 32'd1);
        chk("R8 addr", 32'(ptr_addr), (b == 0) ? 32'(v.pa) : 32'({8'h00, v.pa[15:0] + 16'd1}));
        for (int s = 0; s < stall; s++) begin
          @(negedge clk);
          chk("R8 stall req", 32'(ptr_req), 32'd1);
          chk("R8 stall addr", 32'(ptr_addr), (b == 0) ? 32'(v.pa) : 32'({8'h00, v.pa[15:0] + 16'd1}));
        end
        ptr_ack = 1'b1;
        ptr_byte = (b == 0) ? v.plo : v.phi;
        @(negedge clk);
        ptr_ack = 1'b0;
      end
    end
    chk(ind ? "R8 done" : "R1 done", 32'(done), 32'd1);
    chk(addr_tag(v), 32'(eff_addr), 32'(v.ea));
    chk(ext_tag(v), 32'(extra_cyc), 32'(v.ext));
    @(negedge clk);
    chk("R1 pulse", 32'(done), 32'd0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=50000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 done", 32'(done), 32'd0);
    chk("R11 busy", 32'(busy), 32'd0);
    chk("R11 req", 32'(ptr_req), 32'd0);
    chk("R11 ea", 32'(eff_addr), 32'd0);
    chk("R11 extra", 32'(extra_cyc), 32'd0);

    for (int i = 0; i < 21; i++) run_vec(VECS[i], 0);

    // R8: stalled acknowledge
    run_vec(VECS[16], 3);

    // R10: a start during a fetch is ignored
    @(negedge clk);
    load(VECS[15]);
    start = 1'b1;
    @(negedge clk);
    load(VECS[6]);
    chk("R10 busy", 32'(busy), 32'd1);
    @(negedge clk);
    start = 1'b0;
    chk("R10 no done", 32'(done), 32'd0);
    chk("R10 addr", 32'(ptr_addr), 32'(VECS[15].pa));
    ptr_ack = 1'b1; ptr_byte = VECS[15].plo;
    @(negedge clk);
    ptr_byte = VECS[15].phi;
    @(negedge clk);
    ptr_ack = 1'b0;
    chk("R10 done", 32'(done), 32'd1);
    chk("R10 ea", 32'(eff_addr), 32'(VECS[15].ea));

    // R11: reset mid-fetch clears outputs
    @(negedge clk);
    load(VECS[17]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 req after reset", 32'(ptr_req), 32'd0);
    chk("R11 ea after reset", 32'(eff_addr), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_vec(VECS[0], 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule